// File: doc/BRIEF.md
# Keyed Watchdog with NMI Stage

This block is a watchdog timer set up through a single 32-bit control word. Every write carries a 7-bit key, a run command bit and an 8-bit reload count. As long as the last accepted word had its command bit set, the watchdog is locked: a new word is taken only if its key is the bitwise inverse of the key stored with the last accepted word. Any other write is thrown away whole. An accepted write reloads the down-counter and clears any pending expiry.

The counter moves one step for each pulse on a slow tick-enable input, which is derived outside the block at about 760 pulses per second. When the count runs out for the first time, the block raises a non-maskable interrupt and reloads a short grace count. If software does not service the watchdog before the grace count also runs out, the block issues a one-cycle system reset request and stops. The reset itself is generated outside the block.

Control states: `WS_HALT` (counter stopped, no expiry pending), `WS_ARMED` (counting, no expiry yet), `WS_GRACE` (NMI raised, counting the grace interval) and `WS_SPENT` (reset requested, counter stopped). Transitions: *service-run* (accepted write with command 1, from any state to `WS_ARMED`), *service-stop* (accepted write with command 0, from any state to `WS_HALT`), *first-expiry* (`WS_ARMED` to `WS_GRACE`) and *second-expiry* (`WS_GRACE` to `WS_SPENT`). An accepted write takes priority over an expiry in the same cycle.

Top module: `wdk_top`

## Requirements
- R1: After reset, `nmi` and `rst_req` are 0, the watchdog is unlocked and the counter is stopped, so tick pulses alone never raise `nmi`.
- R2: Control word fields: key in bits [15:9], command in bit 8, reload count in bits [7:0]. While locked, a write whose key is not the bitwise inverse of the stored key is discarded: the count in progress, `nmi` and the stored key are unchanged.
- R3: While unlocked (reset, or last accepted command 0), a write with any key is accepted.
- R4: An accepted write stores its key and command, drives `nmi` low from the next cycle, and loads the counter with the count field.
- R5: A count field of 0 means 256 ticks.
- R6: Command bit 1 starts the count; command bit 0 stops it, and no number of ticks then causes an expiry.
- R7: After an accepted write with count N and command 1, `nmi` goes high in the cycle after the N-th tick pulse.
- R8: After the first expiry, the GRACE-th further tick makes `rst_req` high for exactly one cycle; the counter then stops and no further request follows.
- R9: Once high, `nmi` stays high until an accepted write or reset.
- R10: A tick pulse in the same cycle as an accepted write is ignored; the count starts from the loaded value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe, one cycle per write |
| wr_data | input | 32 | Control word; bits [31:16] are ignored |
| tick | input | 1 | Slow tick enable, one cycle per count step |
| nmi | output | 1 | Non-maskable interrupt, level |
| rst_req | output | 1 | System reset request, one-cycle pulse |

## Verification
The embedded properties take for granted that `wr_en` and `tick` are known after reset and that the GRACE parameter is at least 1, so a running counter never holds zero. They also assume each write strobe is a single-cycle pulse. The bench drives every input at the falling edge, pulses `wr_en` for exactly one cycle per write, and keeps tick pulses one cycle wide with a gap, except for the single case where a tick is placed on purpose in the same cycle as a write.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
    typedef enum logic [1:0] {
        WS_HALT  = 2'd0,
        WS_ARMED = 2'd1,
        WS_GRACE = 2'd2,
        WS_SPENT = 2'd3
    } wd_state_t;
endpackage

// File: rtl/wdk_lock.sv
module wdk_lock #(
    parameter int KEY_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_key,
    input  logic             wr_cmd,
    output logic             accept
);
    logic [KEY_W-1:0] key_q;
    logic             locked_q;

    assign accept = wr_en && (!locked_q || (wr_key == ~key_q));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q    <= '0;
            locked_q <= 1'b0;
        end else if (accept) begin
            key_q    <= wr_key;
            locked_q <= wr_cmd;
        end
    end

    AST_REJECT_KEEPS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !accept) |=> ($stable(key_q) && $stable(locked_q))); // R2
    AST_UNLOCKED_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !wr_cmd) |=> !locked_q); // R3
endmodule

// File: rtl/wdk_count.sv
module wdk_count #(
    parameter int LD_W = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [LD_W-1:0] load_val,
    input  logic            run,
    input  logic            tick,
    output logic            expire
);
    logic [LD_W-1:0] cnt_q;
    localparam logic [LD_W-1:0] ONE = LD_W'(1);

    assign expire = run && tick && (cnt_q == ONE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && tick) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q != '0)); // R5
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt_q)); // R6
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val))); // R10
endmodule

// File: rtl/wdk_fsm.sv
module wdk_fsm
    import wdk_pkg::*;
#(
    parameter int LD_W  = 9,
    parameter int GRACE = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic            wr_cmd,
    input  logic [LD_W-1:0] wr_cnt,
    input  logic            expire,
    output logic            cnt_load,
    output logic [LD_W-1:0] cnt_val,
    output logic            run,
    output logic            nmi,
    output logic            rst_req
);
    localparam logic [LD_W-1:0] GRACE_V = LD_W'(GRACE);

    wd_state_t state_q, state_d;
    logic      nmi_q, rst_req_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (accept) begin
            state_d = wr_cmd ? WS_ARMED : WS_HALT;
        end else begin
            unique case (state_q)
                WS_HALT:  state_d = WS_HALT;
                WS_ARMED: if (expire) state_d = WS_GRACE;
                WS_GRACE: if (expire) state_d = WS_SPENT;
                WS_SPENT: state_d = WS_SPENT;
                default:  state_d = WS_HALT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WS_HALT;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q     <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= 1'b0;
            if (accept) begin
                nmi_q <= 1'b0;
            end else begin
                unique case (state_q)
                    WS_ARMED: if (expire) nmi_q <= 1'b1;
                    WS_GRACE: if (expire) rst_req_q <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    assign run      = (state_q == WS_ARMED) || (state_q == WS_GRACE);
    assign cnt_load = accept || (expire && (state_q == WS_ARMED));
    assign cnt_val  = accept ? wr_cnt : GRACE_V;
    assign nmi      = nmi_q;
    assign rst_req  = rst_req_q;

    AST_NMI_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !nmi); // R4
    AST_NMI_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi) |-> ($past(state_q) == WS_ARMED)); // R7
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R8
    AST_RST_AFTER_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (nmi && state_q == WS_SPENT)); // R8
    AST_SPENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_SPENT) |-> !run); // R8
    AST_NMI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi && !accept) |=> nmi); // R9
endmodule

// File: rtl/wdk_top.sv
module wdk_top
    import wdk_pkg::*;
#(
    parameter int KEY_W  = 7,
    parameter int CNT_W  = 8,
    parameter int GRACE  = 1,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick,
    output logic              nmi,
    output logic              rst_req
);
    localparam int CMD_BIT = CNT_W;
    localparam int KEY_LSB = CNT_W + 1;
    localparam int USED_W  = KEY_LSB + KEY_W;
    localparam int LD_W    = CNT_W + 1;

    logic [KEY_W-1:0] f_key;
    logic             f_cmd;
    logic [CNT_W-1:0] f_cnt;
    logic [LD_W-1:0]  f_cnt_ext;
    logic             unused_hi;

    assign f_key     = wr_data[KEY_LSB +: KEY_W];
    assign f_cmd     = wr_data[CMD_BIT];
    assign f_cnt     = wr_data[CNT_W-1:0];
    assign f_cnt_ext = (f_cnt == '0) ? (LD_W'(1) << CNT_W) : {1'b0, f_cnt};
    assign unused_hi = ^wr_data[DATA_W-1:USED_W];

    logic            accept, expire, cnt_load, run;
    logic [LD_W-1:0] cnt_val;

    wdk_lock #(.KEY_W(KEY_W)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_key (f_key),
        .wr_cmd (f_cmd),
        .accept (accept)
    );

    wdk_count #(.LD_W(LD_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .run      (run),
        .tick     (tick),
        .expire   (expire)
    );

    wdk_fsm #(.LD_W(LD_W), .GRACE(GRACE)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .wr_cmd   (f_cmd),
        .wr_cnt   (f_cnt_ext),
        .expire   (expire),
        .cnt_load (cnt_load),
        .cnt_val  (cnt_val),
        .run      (run),
        .nmi      (nmi),
        .rst_req  (rst_req)
    );

    AST_ZERO_IS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && f_cnt == '0) |-> (cnt_val > LD_W'((1 << CNT_W) - 1))); // R5
endmodule

// File: tb/wdk_top_tb_top.sv
module wdk_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        tick = 1'b0;
    logic        nmi, rst_req;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    wdk_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tick(tick), .nmi(nmi), .rst_req(rst_req)
    );

    function automatic logic [31:0] word(input logic [6:0] key, input logic cmd,
                                         input logic [7:0] cnt);
        return {16'h0, key, cmd, cnt};
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) pulse_tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 nmi after reset", nmi, 1'b0);
        chk("R1 rst_req after reset", rst_req, 1'b0);
        ticks(300);
        chk("R1 stopped counter ignores ticks", nmi, 1'b0);
    endtask

    task automatic t_expiry();
        do_write(word(7'h2A, 1'b1, 8'd3));
        ticks(2);
        chk("R7 no nmi before N-th tick", nmi, 1'b0);
        pulse_tick();
        chk("R7 nmi after N-th tick", nmi, 1'b1);
        chk("R8 no request at first expiry", rst_req, 1'b0);
        pulse_tick();
        chk("R8 request after grace", rst_req, 1'b1);
        @(negedge clk);
        chk("R8 request is one cycle", rst_req, 1'b0);
        for (int i = 0; i < 5; i++) begin
            pulse_tick();
            chk("R8 no second request", rst_req, 1'b0);
        end
        chk("R9 nmi still held", nmi, 1'b1);
    endtask

    task automatic t_reject();
        do_write(word(7'h2A, 1'b1, 8'd1));
        chk("R2 wrong key leaves nmi", nmi, 1'b1);
        chk("R9 nmi held after rejected write", nmi, 1'b1);
        do_write(word(7'h55, 1'b1, 8'd2));
        chk("R4 accepted write clears nmi", nmi, 1'b0);
        pulse_tick();
        chk("R4 count loaded, one tick left", nmi, 1'b0);
        pulse_tick();
        chk("R4 expiry at loaded count", nmi, 1'b1);
        do_write(word(7'h2A, 1'b1, 8'd5));
        ticks(2);
        do_write(word(7'h11, 1'b1, 8'd1));
        pulse_tick();
        chk("R2 rejected count not loaded", nmi, 1'b0);
        pulse_tick();
        chk("R2 count continues", nmi, 1'b0);
        pulse_tick();
        chk("R2 expiry at original count", nmi, 1'b1);
    endtask

    task automatic t_stop_and_full();
        do_write(word(7'h55, 1'b0, 8'd1));
        chk("R4 stop write clears nmi", nmi, 1'b0);
        ticks(10);
        chk("R6 stopped counter never expires", nmi, 1'b0);
        do_write(word(7'h03, 1'b1, 8'd0));
        ticks(255);
        chk("R5 no expiry at 255 ticks", nmi, 1'b0);
        chk("R3 unlocked write accepted (counting)", rst_req, 1'b0);
        pulse_tick();
        chk("R5 zero count expires at 256", nmi, 1'b1);
        pulse_tick();
        chk("R8 request after grace", rst_req, 1'b1);
    endtask

    task automatic t_collide();
        @(negedge clk);
        wr_en = 1'b1; wr_data = word(7'h7C, 1'b1, 8'd2); tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        chk("R9 accepted write releases nmi", nmi, 1'b0);
        pulse_tick();
        chk("R10 simultaneous tick ignored", nmi, 1'b0);
        pulse_tick();
        chk("R10 expiry at full count", nmi, 1'b1);
    endtask

    task automatic t_reset_mid();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset clears nmi", nmi, 1'b0);
        do_write(word(7'h10, 1'b1, 8'd1));
        pulse_tick();
        chk("R3 any key accepted after reset", nmi, 1'b1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_expiry();
                t_reject();
                t_stop_and_full();
                t_collide();
                t_reset_mid();
            end
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule